// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table in memory. A requester presents an address while the walker is idle. The walker checks the top index against a table-length input. It then fetches an entry from the outer table, whose location comes from a table-base input. That entry points to an inner table page, and the walker fetches a second entry from it. The second entry supplies the frame. The result is either a physical address or a fault with a code saying where the walk stopped.

Memory is reached through a plain request/response read port with at most one read in flight. Each read is a single-cycle request pulse with its address. It is answered later by a single-cycle response carrying the 32-bit entry. The walker keeps no cached entries and never writes to memory.

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits into three fields: bits 9:0 are the page offset, bits 19:10 index the inner table, and bits 31:20 index the outer table.
- R2: The cycle after a request is accepted without a length fault, the walker raises mem_req_valid for exactly one cycle with mem_req_addr = tbl_base + 4 × outer index.
- R3: If the outer index is greater than or equal to tbl_len, the cycle after acceptance shows done=1, fault=1 and fault_code=1, and no memory read is issued.
- R4: A table entry is valid when bit 0 is 1, and bits 31:10 hold the base of the next level. After a valid outer entry, the next cycle issues one read at (entry with bits 9:0 cleared) + 4 × inner index.
- R5: An outer entry with bit 0 clear ends the walk with fault=1 and fault_code=2 in the cycle after the response, and no second read is issued.
- R6: An inner entry with bit 0 clear ends the walk with fault=1 and fault_code=3 in the cycle after the response.
- R7: A valid inner entry gives done=1, fault=0, fault_code=0 in the cycle after the response, with paddr = {entry bits 31:10, virtual bits 9:0}.
- R8: At most one read is outstanding. No request is issued while the walker waits for a response, and no read is issued when the walk does not call for one.
- R9: req_ready is 1 only while idle. A request is taken only in a cycle where req_ready is 1. req_valid during a walk or during the result cycle is ignored, and req_ready returns the cycle after done.
- R10: done is a one-cycle pulse for each accepted request.
- R11: After reset the walker is idle: req_ready=1, done=0, mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request will be taken |
| tbl_base | input | 32 | Byte address of the outer table |
| tbl_len | input | 13 | Number of outer entries in use |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_resp_valid | input | 1 | Read data present this cycle |
| mem_resp_data | input | 32 | Entry read from memory |
| done | output | 1 | Result pulse |
| fault | output | 1 | Walk ended in a fault (valid with done) |
| fault_code | output | 2 | 0 none, 1 length, 2 outer invalid, 3 inner invalid |
| paddr | output | 32 | Physical address (valid with done and no fault) |

## Verification
Two events can land on the same cycle: the result pulse of one walk, and a new request from a requester that holds req_valid high with its next address. The bench chains requests this way with a mix of good walks, length faults and invalid entries. A behavioural model then decides, cycle by cycle, whether the walker must take the request, and compares req_ready, done and the memory port on every clock. A design that takes the waiting request during the result cycle, rather than one cycle later, shows a wrong read address or a wrong ready in that cycle.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_OUT,
    S_WT_OUT,
    S_RD_IN,
    S_WT_IN,
    S_DONE,
    S_FAULT
  } walk_state_t;

  typedef enum logic [1:0] {
    FC_NONE   = 2'd0,
    FC_LENGTH = 2'd1,
    FC_OUTER  = 2'd2,
    FC_INNER  = 2'd3
  } fault_code_t;

endpackage

// File: rtl/pgw_vaddr_split.sv
module pgw_vaddr_split #(
  parameter int OFF_W = 10,
  parameter int IN_W  = 10,
  parameter int OUT_W = 12,
  localparam int VA_W  = OUT_W + IN_W + OFF_W,
  localparam int LEN_W = OUT_W + 1
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LEN_W-1:0] len,
  output logic [OUT_W-1:0] outer_idx,
  output logic [IN_W-1:0]  inner_idx,
  output logic [OFF_W-1:0] offset,
  output logic             beyond
);
  // Field extraction: top index, inner index, byte offset
  always_comb begin
    offset    = vaddr[OFF_W-1:0];
    inner_idx = vaddr[OFF_W +: IN_W];
    outer_idx = vaddr[VA_W-1 -: OUT_W];
    beyond    = {1'b0, outer_idx} >= len;
  end
endmodule

// File: rtl/pgw_pte_decode.sv
module pgw_pte_decode #(
  parameter int PTE_W = 32,
  parameter int OFF_W = 10
) (
  input  logic [PTE_W-1:0] pte,
  output logic             valid,
  output logic [PTE_W-1:0] base
);
  logic unused_rsvd_bits;

  always_comb begin
    valid            = pte[0];
    base             = {pte[PTE_W-1:OFF_W], {OFF_W{1'b0}}};
    unused_rsvd_bits = ^pte[OFF_W-1:1];
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pgw_pkg::*;
#(
  parameter int PA_W        = 32,
  parameter int OFF_W       = 10,
  parameter int IN_W        = 10,
  parameter int OUT_W       = 12,
  parameter int ENTRY_BYTES = 4,
  localparam int VA_W  = OUT_W + IN_W + OFF_W,
  localparam int LEN_W = OUT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [LEN_W-1:0] tbl_len,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_resp_valid,
  input  logic [PA_W-1:0]  mem_resp_data,
  output logic             done,
  output logic             fault,
  output logic [1:0]       fault_code,
  output logic [PA_W-1:0]  paddr
);
  localparam int ENT_SH = $clog2(ENTRY_BYTES);

  walk_state_t       st;
  fault_code_t       fc_q;
  logic [PA_W-1:0]   rd_addr_q;
  logic [PA_W-1:0]   paddr_q;
  logic [IN_W-1:0]   in_idx_q;
  logic [OFF_W-1:0]  off_q;

  logic [OUT_W-1:0]  s_out;
  logic [IN_W-1:0]   s_in;
  logic [OFF_W-1:0]  s_off;
  logic              s_beyond;
  logic              pte_ok;
  logic [PA_W-1:0]   pte_base;

  pgw_vaddr_split #(.OFF_W(OFF_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_split (
    .vaddr     (req_vaddr),
    .len       (tbl_len),
    .outer_idx (s_out),
    .inner_idx (s_in),
    .offset    (s_off),
    .beyond    (s_beyond)
  );

  pgw_pte_decode #(.PTE_W(PA_W), .OFF_W(OFF_W)) u_pte (
    .pte   (mem_resp_data),
    .valid (pte_ok),
    .base  (pte_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      fc_q      <= FC_NONE;
      rd_addr_q <= '0;
      paddr_q   <= '0;
      in_idx_q  <= '0;
      off_q     <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          in_idx_q <= s_in;
          off_q    <= s_off;
          if (s_beyond) begin
            fc_q <= FC_LENGTH;
            st   <= S_FAULT;
          end else begin
            fc_q      <= FC_NONE;
            rd_addr_q <= tbl_base + (PA_W'(s_out) << ENT_SH);
            st        <= S_RD_OUT;
          end
        end
        S_RD_OUT: st <= S_WT_OUT;
        S_WT_OUT: if (mem_resp_valid) begin
          if (!pte_ok) begin
            fc_q <= FC_OUTER;
            st   <= S_FAULT;
          end else begin
            rd_addr_q <= pte_base + (PA_W'(in_idx_q) << ENT_SH);
            st        <= S_RD_IN;
          end
        end
        S_RD_IN: st <= S_WT_IN;
        S_WT_IN: if (mem_resp_valid) begin
          if (!pte_ok) begin
            fc_q <= FC_INNER;
            st   <= S_FAULT;
          end else begin
            paddr_q <= pte_base | PA_W'(off_q);
            st      <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (st == S_IDLE);
    mem_req_valid = (st == S_RD_OUT) || (st == S_RD_IN);
    mem_req_addr  = rd_addr_q;
    done          = (st == S_DONE) || (st == S_FAULT);
    fault         = (st == S_FAULT);
    fault_code    = fc_q;
    paddr         = paddr_q;
  end

  AST_LEN_FAULT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && s_beyond) |=> (done && fault && fault_code == 2'd1 && !mem_req_valid)); // R3
  AST_ACCEPT_READ: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && !s_beyond) |=> (mem_req_valid && !done)); // R2
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid); // R8
  AST_OUTER_BAD: assert property (@(posedge clk) disable iff (rst)
    (st == S_WT_OUT && mem_resp_valid && !mem_resp_data[0]) |=> (fault && fault_code == 2'd2 && !mem_req_valid)); // R5
  AST_INNER_BAD: assert property (@(posedge clk) disable iff (rst)
    (st == S_WT_IN && mem_resp_valid && !mem_resp_data[0]) |=> (fault && fault_code == 2'd3)); // R6
  AST_FRAME_OUT: assert property (@(posedge clk) disable iff (rst)
    (st == S_WT_IN && mem_resp_valid && mem_resp_data[0]) |=>
      (done && !fault && paddr[PA_W-1:OFF_W] == $past(mem_resp_data[PA_W-1:OFF_W]))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready)); // R10
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || done) |-> !req_ready); // R9
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic [31:0] tbl_base = 32'h0001_0000;
  logic [12:0] tbl_len = 13'h800;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_data = '0;
  logic        done, fault;
  logic [1:0]  fault_code;
  logic [31:0] paddr;

  always #5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .tbl_base(tbl_base), .tbl_len(tbl_len),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .done(done), .fault(fault), .fault_code(fault_code), .paddr(paddr)
  );

  int compared = 0;
  int mismatched = 0;
  logic [31:0] pmem [int unsigned];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mkva(input int o, input int i, input int off);
    return {o[11:0], i[9:0], off[9:0]};
  endfunction

  // behavioural reference: expectations keyed by cycle number
  int          cyc = 0;
  int          lat = 1;
  bit          busy = 0;
  int          acc_cnt = 0;
  int          exp_done_cyc = -1;
  int          exp_mreq_cyc = -1;
  int          resp_cyc = -1;
  int          mreq_level = 0;
  int          resp_level = 0;
  logic [31:0] exp_maddr, resp_word, cur_va, exp_pa;
  logic [1:0]  exp_code;
  string       done_tag;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      busy = 0; exp_done_cyc = -1; exp_mreq_cyc = -1; resp_cyc = -1;
      mem_resp_valid = 1'b0;
    end else begin
      chk("R9 req_ready", {31'b0, req_ready}, {31'b0, !busy});
      chk("R10 done pulse", {31'b0, done}, {31'b0, cyc == exp_done_cyc});
      if (cyc == exp_done_cyc) begin
        chk({done_tag, " fault"}, {31'b0, fault}, {31'b0, exp_code != 2'd0});
        chk({done_tag, " fault_code"}, {30'b0, fault_code}, {30'b0, exp_code});
        if (exp_code == 2'd0) chk("R1 R7 paddr", paddr, exp_pa);
      end
      if (cyc == exp_mreq_cyc) begin
        chk(mreq_level == 1 ? "R2 outer read" : "R4 inner read", {31'b0, mem_req_valid}, 32'd1);
        chk(mreq_level == 1 ? "R2 outer addr" : "R4 inner addr", mem_req_addr, exp_maddr);
        resp_cyc   = cyc + lat;
        resp_word  = rd(exp_maddr);
        resp_level = mreq_level;
      end else begin
        chk("R8 no extra read", {31'b0, mem_req_valid}, 32'd0);
      end
      if (cyc == resp_cyc) begin
        mem_resp_valid = 1'b1;
        mem_resp_data  = resp_word;
        if (resp_level == 1) begin
          if (!resp_word[0]) begin
            exp_done_cyc = cyc + 1; exp_code = 2'd2; done_tag = "R5";
          end else begin
            exp_mreq_cyc = cyc + 1; mreq_level = 2;
            exp_maddr = (resp_word & ~32'h3FF) + {20'b0, cur_va[19:10], 2'b00};
          end
        end else begin
          exp_done_cyc = cyc + 1;
          if (!resp_word[0]) begin
            exp_code = 2'd3; done_tag = "R6";
          end else begin
            exp_code = 2'd0; done_tag = "R7";
            exp_pa = (resp_word & ~32'h3FF) | {22'b0, cur_va[9:0]};
          end
        end
      end else begin
        mem_resp_valid = 1'b0;
        mem_resp_data  = 32'hDEAD_BEEF ^ cyc;
      end
      if (!busy && req_valid) begin
        acc_cnt++;
        busy   = 1;
        cur_va = req_vaddr;
        if ({1'b0, req_vaddr[31:20]} >= tbl_len) begin
          exp_done_cyc = cyc + 1; exp_code = 2'd1; done_tag = "R3";
        end else begin
          exp_mreq_cyc = cyc + 1; mreq_level = 1;
          exp_maddr = tbl_base + {18'b0, req_vaddr[31:20], 2'b00};
        end
      end else if (cyc == exp_done_cyc) begin
        busy = 0;
      end
    end
  end

  task automatic do_req(input logic [31:0] va, input int l, input bit hold);
    int a;
    @(posedge clk); #1;
    req_valid = 1'b1; req_vaddr = va; lat = l;
    a = acc_cnt;
    while (acc_cnt == a) @(negedge clk);
    if (!hold) begin
      @(posedge clk); #1;
      req_valid = 1'b0;
      while (busy) @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    pmem[32'h0001_0000 + 5*4]      = 32'h0002_0001;
    pmem[32'h0002_0000 + 18*4]     = 32'hABCD_E401;
    pmem[32'h0002_0000 + 19*4]     = 32'h5555_5400;
    pmem[32'h0001_0000 + 32'h7FF*4] = 32'h0003_0001;
    pmem[32'h0003_0000 + 32'h3FF*4] = 32'h1234_5C01;
    pmem[32'h0001_0000 + 7*4]      = 32'h0004_0000;
    pmem[32'h0001_0000]            = 32'h0005_0001;
    pmem[32'h0005_0000]            = 32'h0000_0401;

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    // R11 reset state
    chk("R11 ready", {31'b0, req_ready}, 32'd1);
    chk("R11 done", {31'b0, done}, 32'd0);
    chk("R11 mem_req", {31'b0, mem_req_valid}, 32'd0);

    do_req(mkva(5, 18, 32'h123), 1, 0);       // R7 good walk
    do_req(mkva(5, 18, 32'h3FF), 3, 0);       // R1 offset all ones
    do_req(mkva(32'h7FF, 32'h3FF, 0), 2, 0);  // R3 boundary len-1 passes
    do_req(mkva(32'h800, 0, 5), 1, 0);        // R3 index equals len
    do_req(mkva(32'hFFF, 7, 5), 1, 0);        // R3 far beyond
    do_req(mkva(6, 1, 1), 2, 0);              // R5 empty outer entry
    do_req(mkva(7, 1, 1), 1, 0);              // R5 base set, valid clear
    do_req(mkva(5, 19, 9), 4, 0);             // R6 invalid inner entry
    // R9: requests held back to back, next one waiting during result cycle
    do_req(mkva(0, 0, 32'h2A), 1, 1);
    do_req(mkva(32'h800, 3, 3), 2, 1);
    do_req(mkva(5, 18, 7), 1, 1);
    do_req(mkva(6, 0, 0), 1, 1);
    do_req(mkva(32'h7FF, 32'h3FF, 32'h200), 3, 0);
    // R3 zero length faults everything
    @(posedge clk); #1 tbl_len = 13'd0;
    do_req(mkva(0, 0, 1), 1, 0);
    // full length: top index reaches an empty entry
    @(posedge clk); #1 tbl_len = 13'h1000;
    do_req(mkva(32'hFFF, 2, 2), 2, 0);
    repeat (5) @(posedge clk);
    summary();
  end
endmodule